// File: doc/BRIEF.md
# Pipelined-Borrow Programmable Timer Divider

Four 8-bit programmable down-counters that divide either the system clock or a slow base tick and emit a one-cycle timeout pulse each time they expire. Adjacent channels can be chained: channel 0 drives channel 1 and channel 2 drives channel 3. Each such pair then behaves as one 16-bit divider. The lower byte comes from the lower channel and the upper byte from the upper channel.

Zero detection is not immediate. A channel that reaches zero on an enabled cycle sends a borrow through a three-stage register chain. Only then does it reload its divisor and pulse. A standalone channel running on the system clock therefore has a period of divisor + 4 cycles. A chained pair passes through both chains and a final reload, so its period is divisor + 7 cycles.

The slow base tick comes from an internal prescaler. It runs in one of two rates, a fast base (default every 28 clocks) or a slow base (default every 114 clocks). The divisor inputs are levels, and a channel samples its divisor only when it reloads.

Top module: `tmr_divider`

## Requirements
- R1: A standalone channel (0 or 2) whose system-clock select bit is set gives a timeout pulse every D+4 clock cycles, where D is its 8-bit divisor. D=0 gives 4 cycles and D=255 gives 259.
- R2: With link bit k set, channels 2k and 2k+1 form a 16-bit divider with value {div of channel 2k+1, div of channel 2k}. With channel 2k on the system clock, channel 2k+1 pulses every value+7 cycles.
- R3: A channel on the base tick expires only on tick cycles. With tick period P it pulses every (D+1)·P cycles, so D=0 runs at exactly the tick rate. A linked pair on the base tick pulses every (value+1)·P cycles.
- R4: base_sel_i = 0 gives a tick period of FAST_DIV cycles. base_sel_i = 1 gives SLOW_DIV cycles.
- R5: Only channels 0 and 2 can use the system clock, through fast_clk_i[0] and fast_clk_i[1]. An unlinked channel 1 or 3 always runs on the base tick, whatever fast_clk_i holds.
- R6: Every timeout pulse lasts exactly one clock cycle.
- R7: Bits [8k+7:8k] of div_i are the divisor of channel k. Bit k of timeout_o is the timeout of channel k.
- R8: A divisor change takes effect only at the next reload. The period in progress keeps its old length.
- R9: While rst_ni is low, all timeout outputs stay low and all counters and borrow stages are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div_i | input | 32 | Divisors, byte k for channel k |
| base_sel_i | input | 1 | Base tick rate: 0 fast base, 1 slow base |
| fast_clk_i | input | 2 | Bit 0: channel 0 on system clock; bit 1: channel 2 on system clock |
| link_i | input | 2 | Bit 0 chains 0→1, bit 1 chains 2→3 |
| timeout_o | output | 4 | One-cycle expiry pulse per channel |

## Verification
Two events can collide in one cycle.

- **Divisor write against a reload.** A new divisor can be written in the very cycle a reload has just sampled the old one. The bench provokes this by changing the divisor on the clock phase right after a timeout is seen. It then expects one more period of the old length followed by periods of the new length.
- **Lower-half borrow against terminal zero.** In a linked pair, the lower channel's wrap-borrow and the pair's terminal zero are the same zero-detect event, told apart only by the upper half. The bench probes this with 16-bit values whose low byte is 0 or 255 and whose high byte is 0 or 1. Each measured period is compared with value+7.

// File: rtl/tmr_div_pkg.sv
`timescale 1ns/1ps
package tmr_div_pkg;
  localparam int unsigned BORROW_STAGES = 3;
  typedef enum logic {BASE_FAST = 1'b0, BASE_SLOW = 1'b1} base_sel_e;
endpackage

// File: rtl/tmr_div_prescale.sv
`timescale 1ns/1ps
module tmr_div_prescale #(
  parameter int unsigned FAST_DIV = 28,
  parameter int unsigned SLOW_DIV = 114
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic base_sel_i,
  output logic tick_o
);
  localparam int unsigned MAXDIV = (FAST_DIV > SLOW_DIV) ? FAST_DIV : SLOW_DIV;
  localparam int unsigned PW     = $clog2(MAXDIV);

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] limit;
  logic          tick_q;

  assign limit = (base_sel_i == tmr_div_pkg::BASE_SLOW) ? PW'(SLOW_DIV - 1) : PW'(FAST_DIV - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= (cnt_q >= limit);
      cnt_q  <= (cnt_q >= limit) ? '0 : cnt_q + 1'b1;
    end
  end

  assign tick_o = tick_q;

  p_tick_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q |=> !tick_q);
endmodule

// File: rtl/tmr_div_chan.sv
`timescale 1ns/1ps
module tmr_div_chan #(
  parameter int unsigned CW     = 8,
  parameter int unsigned STAGES = tmr_div_pkg::BORROW_STAGES
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          is_lo_i,       // lower half of an active pair
  input  logic          upper_zero_i,  // upper half is zero
  input  logic          pair_reload_i, // upper half reloads the pair
  input  logic [CW-1:0] div_i,
  output logic          zero_o,
  output logic          borrow_o,
  output logic          timeout_o
);
  logic [CW-1:0]     cnt_q;
  logic [STAGES-1:0] pipe_q;
  logic              term_q;
  logic              to_q;
  logic              zero;
  logic              hold;
  logic              launch;

  assign zero   = (cnt_q == '0);
  assign hold   = is_lo_i ? term_q : |pipe_q;
  assign launch = en_i & zero & ~hold;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pipe_q <= '0;
      term_q <= 1'b0;
      to_q   <= 1'b0;
    end else begin
      pipe_q <= {pipe_q[STAGES-2:0], launch};
      to_q   <= pipe_q[STAGES-1];
      if (is_lo_i) begin
        if (pair_reload_i) begin
          cnt_q  <= div_i;
          term_q <= 1'b0;
        end else if (launch) begin
          // terminal zero freezes; otherwise wrap and borrow from upper half
          if (upper_zero_i) term_q <= 1'b1;
          else              cnt_q  <= '1;
        end else if (en_i && !zero) begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else begin
        term_q <= 1'b0;
        if (pipe_q[STAGES-1])   cnt_q <= div_i;
        else if (en_i && !zero) cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign zero_o    = zero;
  assign borrow_o  = pipe_q[STAGES-1];
  assign timeout_o = to_q;

  p_pulse_once_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_q |=> !to_q);
  p_count_down_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !zero && !pair_reload_i) |=> cnt_q == CW'($past(cnt_q) - 1'b1));
  p_reload_div_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_lo_i && pipe_q[STAGES-1]) |=> cnt_q == $past(div_i));
  p_freeze_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_q |-> zero);
endmodule

// File: rtl/tmr_divider.sv
`timescale 1ns/1ps
module tmr_divider #(
  parameter int unsigned CW       = 8,
  parameter int unsigned FAST_DIV = 28,
  parameter int unsigned SLOW_DIV = 114
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [4*CW-1:0]  div_i,
  input  logic             base_sel_i,
  input  logic [1:0]       fast_clk_i,
  input  logic [1:0]       link_i,
  output logic [3:0]       timeout_o
);
  localparam int unsigned NCH = 4;

  logic       tick;
  logic [NCH-1:0] en, zero, borrow, to;

  tmr_div_prescale #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_pre (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .base_sel_i (base_sel_i),
    .tick_o     (tick)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    localparam int unsigned P = k / 2;
    if (k % 2 == 0) begin : g_lo
      assign en[k] = fast_clk_i[P] ? 1'b1 : tick;
      tmr_div_chan #(.CW(CW)) u_ch (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .en_i          (en[k]),
        .is_lo_i       (link_i[P]),
        .upper_zero_i  (zero[k+1]),
        .pair_reload_i (link_i[P] & borrow[k+1]),
        .div_i         (div_i[k*CW +: CW]),
        .zero_o        (zero[k]),
        .borrow_o      (borrow[k]),
        .timeout_o     (to[k])
      );
    end else begin : g_hi
      // upper channels never see the system clock directly
      assign en[k] = link_i[P] ? borrow[k-1] : tick;
      tmr_div_chan #(.CW(CW)) u_ch (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .en_i          (en[k]),
        .is_lo_i       (1'b0),
        .upper_zero_i  (1'b1),
        .pair_reload_i (1'b0),
        .div_i         (div_i[k*CW +: CW]),
        .zero_o        (zero[k]),
        .borrow_o      (borrow[k]),
        .timeout_o     (to[k])
      );
    end
  end

  assign timeout_o = to;

  p_upper_en_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!link_i[0] && en[1]) |-> tick);
  p_reset_quiet_r9: assert property (@(posedge clk_i)
    !rst_ni |-> timeout_o == '0);
endmodule

// File: tb/tmr_divider_test.sv
`timescale 1ns/1ps
module tmr_divider_test;
  localparam int FD = 28;
  localparam int SD = 114;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] div_i = '0;
  logic        base_sel_i = 1'b0;
  logic [1:0]  fast_clk_i = '0;
  logic [1:0]  link_i = '0;
  logic [3:0]  timeout_o;

  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tmr_divider #(.CW(8), .FAST_DIV(FD), .SLOW_DIV(SD)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .div_i(div_i), .base_sel_i(base_sel_i),
    .fast_clk_i(fast_clk_i), .link_i(link_i), .timeout_o(timeout_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic setup(input bit bs, input logic [1:0] fc, input logic [1:0] lk,
                       input logic [31:0] dv);
    @(negedge clk);
    rst_ni = 1'b0;
    base_sel_i = bs; fast_clk_i = fc; link_i = lk; div_i = dv;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  // waits for four pulses on channel ch and checks the last two intervals
  task automatic meas(input int ch, input int exp, input string tag);
    int t[4];
    int n = 0;
    int w = 0;
    int lim = exp * 6 + 300;
    while (n < 4 && w < lim) begin
      @(negedge clk);
      w++;
      if (timeout_o[ch]) begin t[n] = cyc; n++; end
    end
    if (n < 4) check({tag, " pulses"}, n, 4);
    else begin
      check(tag, t[2] - t[1], exp);
      check(tag, t[3] - t[2], exp);
    end
  endtask

  task automatic wait_pulse(input int ch, output int t);
    int w = 0;
    t = -1;
    while (w < 20000) begin
      @(negedge clk);
      w++;
      if (timeout_o[ch]) begin t = cyc; break; end
    end
  endtask

  initial begin
    #(5.0 * 190000);
    n_bad++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
    $finish;
  end

  initial begin
    int t0, t1, t2;
    // R9: quiet during reset even with system-clock channels enabled
    fast_clk_i = 2'b11;
    repeat (10) @(negedge clk);
    check("R9 timeouts in reset", int'(timeout_o), 0);
    @(negedge clk);
    check("R9 timeouts in reset late", int'(timeout_o), 0);

    // R1, R7: standalone system clock, D+4
    setup(1'b0, 2'b01, 2'b00, 32'h0000_0000); meas(0, 4,   "R1 ch0 D=0");
    setup(1'b0, 2'b01, 2'b00, 32'h0000_0001); meas(0, 5,   "R1 ch0 D=1");
    setup(1'b0, 2'b01, 2'b00, 32'h0000_00FF); meas(0, 259, "R1 ch0 D=255");
    setup(1'b0, 2'b10, 2'b00, 32'h0007_0000); meas(2, 11,  "R7 ch2 D=7");

    // R6: pulse is one cycle wide at the shortest period
    setup(1'b0, 2'b01, 2'b00, 32'h0000_0000);
    wait_pulse(0, t0);
    @(negedge clk);
    check("R6 pulse width", int'(timeout_o[0]), 0);

    // R3, R4: base tick
    setup(1'b0, 2'b00, 2'b00, 32'h0000_0000); meas(0, FD,       "R3 ch0 D=0 fast base");
    setup(1'b0, 2'b00, 2'b00, 32'h0000_00FF); meas(0, 256 * FD, "R3 ch0 D=255 fast base");
    setup(1'b1, 2'b00, 2'b00, 32'h0000_0000); meas(0, SD,       "R4 ch0 D=0 slow base");
    setup(1'b1, 2'b00, 2'b00, 32'h0100_0000); meas(3, 2 * SD,   "R4 ch3 D=1 slow base");

    // R5: fast bits do not move upper channels off the base tick
    setup(1'b0, 2'b11, 2'b00, 32'h0000_0200); meas(1, 3 * FD, "R5 ch1 D=2 fast bits set");
    setup(1'b0, 2'b11, 2'b00, 32'h0000_0000); meas(3, FD,     "R5 ch3 D=0 fast bits set");

    // R2: linked pairs at system clock, value+7
    setup(1'b0, 2'b01, 2'b01, 32'h0000_0000); meas(1, 7,          "R2 pair0 0x0000");
    setup(1'b0, 2'b01, 2'b01, 32'h0000_0001); meas(1, 8,          "R2 pair0 0x0001");
    setup(1'b0, 2'b01, 2'b01, 32'h0000_00FF); meas(1, 262,        "R2 pair0 0x00FF");
    setup(1'b0, 2'b01, 2'b01, 32'h0000_0100); meas(1, 263,        "R2 pair0 0x0100");
    setup(1'b0, 2'b01, 2'b01, 32'h0000_1234); meas(1, 16'h1234+7, "R2 pair0 0x1234");
    setup(1'b0, 2'b10, 2'b10, 32'h0102_0000); meas(3, 258 + 7,    "R2 pair1 0x0102");

    // R3: linked pair on base tick
    setup(1'b0, 2'b00, 2'b10, 32'h0003_0000); meas(3, 4 * FD, "R3 pair1 0x0003 base");

    // R8: divisor written right after a reload
    setup(1'b0, 2'b01, 2'b00, 32'h0000_000A);
    wait_pulse(0, t0);
    wait_pulse(0, t0);
    div_i[7:0] = 8'd50;
    wait_pulse(0, t1);
    wait_pulse(0, t2);
    check("R8 old period kept", t1 - t0, 14);
    check("R8 new period", t2 - t1, 54);

    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
    $finish;
  end
endmodule